// File: doc/BRIEF.md
# Vertical Sync Coast Generator

This block keeps a vertical sync pulse running when the incoming video drops out. While the video-present flag is high, the output follows the incoming vertical sync. The block also times the interval between successive rising edges of that sync and keeps the most recent value as its learned frame period.

When the video-present flag falls, the block generates vertical sync pulses itself. A 2-bit mode input picks the free-run period. Code 00 and code 11 use the learned period. Code 01 forces a fixed 50 Hz period and code 10 forces a fixed 60 Hz period. Both fixed periods are parameters given in clock cycles. In auto mode, if no period has been learned yet, the 60 Hz period is used. Timing runs on from the last input pulse, so the first generated pulse starts exactly one period after the last rising edge seen on the input.

Top module: `vs_coast_gen`

## Requirements
- R1: While `video_ok` is high, `vs_out` equals the value `vs_in` had one clock earlier.
- R2: With `coast_mode` = 2'b00 and `video_ok` low, generated pulses start every L cycles. L is the number of cycles between the last two `vs_in` rising edges that were both seen while `video_ok` was high.
- R3: With `coast_mode` = 2'b01 and `video_ok` low, generated pulses start every `PERIOD_50` cycles.
- R4: With `coast_mode` = 2'b10 and `video_ok` low, generated pulses start every `PERIOD_60` cycles.
- R5: `coast_mode` = 2'b11 behaves exactly like 2'b00.
- R6: In auto mode (00 or 11), if no period has been learned since reset, coasting uses `PERIOD_60`.
- R7: After `video_ok` falls, the first generated `vs_out` rising edge comes P cycles after the rising edge that `vs_out` showed for the last `vs_in` pulse. P is the selected period.
- R8: Each generated pulse stays high for exactly `PULSE_W` cycles.
- R9: The first `vs_in` rising edge after `video_ok` returns only restarts timing and does not change the learned period. A pair of rising edges seen with video present is needed to relearn it.
- R10: While `rst` is high and on the cycle after it, `vs_out` is low, and no period is learned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vs_in | input | 1 | Incoming vertical sync, active high |
| video_ok | input | 1 | High while valid video is present |
| coast_mode | input | 2 | Free-run period select: 00 auto, 01 50 Hz, 10 60 Hz, 11 auto |
| vs_out | output | 1 | Registered vertical sync output |

## Verification
The bench builds the block with a 12-bit timer, `PERIOD_50` = 240, `PERIOD_60` = 200 and `PULSE_W` = 4. With these values a free-run period lasts a few hundred cycles, so many coast intervals, learned periods and mode changes fit in one short run. Input periods from 60 to 300 cycles are chosen at random, so a learned period can be shorter or longer than either forced period. This shows that the mode, and not the input rate, decides which period is used.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  typedef enum logic [1:0] {
    COAST_AUTO = 2'b00,
    COAST_50   = 2'b01,
    COAST_60   = 2'b10,
    COAST_RSVD = 2'b11
  } coast_mode_e;
endpackage

// File: rtl/vsc_phase_timer.sv
module vsc_phase_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] elapsed
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Cycles since the last restart; saturates rather than wrapping
  always_ff @(posedge clk) begin
    if (rst)
      elapsed <= '0;
    else if (restart)
      elapsed <= CNT_W'(1);
    else if (elapsed != CNT_MAX)
      elapsed <= elapsed + CNT_W'(1);
  end
endmodule

// File: rtl/vsc_period_learn.sv
module vsc_period_learn #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             video_ok,
  input  logic             edge_seen,
  input  logic [CNT_W-1:0] elapsed,
  output logic [CNT_W-1:0] learned,
  output logic             learned_vld
);
  logic armed;

  // armed: the previous edge was taken with video present, so elapsed is a true period
  always_ff @(posedge clk) begin
    if (rst) begin
      armed       <= 1'b0;
      learned     <= '0;
      learned_vld <= 1'b0;
    end else if (!video_ok) begin
      armed <= 1'b0;
    end else if (edge_seen) begin
      armed <= 1'b1;
      if (armed) begin
        learned     <= elapsed;
        learned_vld <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vsc_rate_sel.sv
module vsc_rate_sel
  import vsc_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int PERIOD_50 = 540000,
  parameter int PERIOD_60 = 450450
) (
  input  logic [1:0]       coast_mode,
  input  logic [CNT_W-1:0] learned,
  input  logic             learned_vld,
  output logic [CNT_W-1:0] target
);
  localparam logic [CNT_W-1:0] P50 = CNT_W'(PERIOD_50);
  localparam logic [CNT_W-1:0] P60 = CNT_W'(PERIOD_60);

  always_comb begin
    unique case (coast_mode_e'(coast_mode))
      COAST_50:   target = P50;
      COAST_60:   target = P60;
      default:    target = learned_vld ? learned : P60;
    endcase
  end
endmodule

// File: rtl/vs_coast_gen.sv
module vs_coast_gen #(
  parameter int CNT_W     = 20,
  parameter int PERIOD_50 = 540000,
  parameter int PERIOD_60 = 450450,
  parameter int PULSE_W   = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vs_in,
  input  logic       video_ok,
  input  logic [1:0] coast_mode,
  output logic       vs_out
);
  localparam int PW_W = $clog2(PULSE_W + 1);

  logic             vs_prev;
  logic             in_rise;
  logic             fire;
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] learned;
  logic             learned_vld;
  logic [CNT_W-1:0] target;
  logic [PW_W-1:0]  width_left;

  always_ff @(posedge clk) begin
    if (rst) vs_prev <= 1'b0;
    else     vs_prev <= vs_in;
  end

  assign in_rise = video_ok && vs_in && !vs_prev;
  assign fire    = !video_ok && (elapsed >= target);

  vsc_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .restart (in_rise || fire),
    .elapsed (elapsed)
  );

  vsc_period_learn #(.CNT_W(CNT_W)) learn_i (
    .clk         (clk),
    .rst         (rst),
    .video_ok    (video_ok),
    .edge_seen   (in_rise),
    .elapsed     (elapsed),
    .learned     (learned),
    .learned_vld (learned_vld)
  );

  vsc_rate_sel #(
    .CNT_W     (CNT_W),
    .PERIOD_50 (PERIOD_50),
    .PERIOD_60 (PERIOD_60)
  ) sel_i (
    .coast_mode  (coast_mode),
    .learned     (learned),
    .learned_vld (learned_vld),
    .target      (target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_out     <= 1'b0;
      width_left <= '0;
    end else if (video_ok) begin
      vs_out     <= vs_in;
      width_left <= '0;
    end else if (fire) begin
      vs_out     <= 1'b1;
      width_left <= PW_W'(PULSE_W - 1);
    end else if (width_left != '0) begin
      vs_out     <= 1'b1;
      width_left <= width_left - PW_W'(1);
    end else begin
      vs_out <= 1'b0;
    end
  end
endmodule

// File: rtl/vsc_coast_chk.sv
module vsc_coast_chk #(
  parameter int CNT_W     = 20,
  parameter int PERIOD_50 = 540000,
  parameter int PERIOD_60 = 450450,
  parameter int PULSE_W   = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       vs_in,
  input logic       video_ok,
  input logic [1:0] coast_mode,
  input logic       vs_out
);
  logic             out_d;
  logic [1:0]       mode_d;
  logic [15:0]      hi_run;
  logic [CNT_W:0]   gap;
  logic             gap_vld;
  logic             out_rise;

  assign out_rise = vs_out && !out_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_d   <= 1'b0;
      mode_d  <= 2'b00;
      hi_run  <= '0;
      gap     <= '0;
      gap_vld <= 1'b0;
    end else begin
      out_d  <= vs_out;
      mode_d <= coast_mode;
      if (video_ok || !vs_out)    hi_run <= '0;
      else if (hi_run != 16'hFFFF) hi_run <= hi_run + 16'd1;
      if (video_ok || coast_mode != mode_d) begin
        gap_vld <= 1'b0;
        gap     <= '0;
      end else if (out_rise) begin
        gap_vld <= 1'b1;
        gap     <= (CNT_W+1)'(1);
      end else if (gap != {(CNT_W+1){1'b1}}) begin
        gap <= gap + (CNT_W+1)'(1);
      end
    end
  end

  // R1
  mirror_chk: assert property (@(posedge clk) disable iff (rst)
    video_ok |=> (vs_out == $past(vs_in)));

  // R8
  width_chk: assert property (@(posedge clk) disable iff (rst)
    !video_ok |-> (hi_run <= 16'(PULSE_W)));

  // R3
  rate50_chk: assert property (@(posedge clk) disable iff (rst)
    (!video_ok && coast_mode == 2'b01 && coast_mode == mode_d && gap_vld && out_rise)
      |-> (gap == (CNT_W+1)'(PERIOD_50)));

  // R4
  rate60_chk: assert property (@(posedge clk) disable iff (rst)
    (!video_ok && coast_mode == 2'b10 && coast_mode == mode_d && gap_vld && out_rise)
      |-> (gap == (CNT_W+1)'(PERIOD_60)));

  // R10
  reset_low_chk: assert property (@(posedge clk)
    rst |=> !vs_out);
endmodule

bind vs_coast_gen vsc_coast_chk #(
  .CNT_W     (CNT_W),
  .PERIOD_50 (PERIOD_50),
  .PERIOD_60 (PERIOD_60),
  .PULSE_W   (PULSE_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .vs_in      (vs_in),
  .video_ok   (video_ok),
  .coast_mode (coast_mode),
  .vs_out     (vs_out)
);

// File: tb/vs_coast_gen_tb_top.sv
module vs_coast_gen_tb_top;
  localparam int CNT_W = 12;
  localparam int P50   = 240;
  localparam int P60   = 200;
  localparam int PW    = 4;
  localparam int IN_W  = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       vs_in = 1'b0;
  logic       video_ok = 1'b0;
  logic [1:0] coast_mode = 2'b00;
  logic       vs_out;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  int rise_cnt = 0;
  int last_rise = 0;
  int prev_rise = 0;
  int last_width = 0;
  int hi_len = 0;
  int in_rise = 0;
  logic prev_out = 1'b0;
  bit done = 1'b0;

  vs_coast_gen #(
    .CNT_W(CNT_W), .PERIOD_50(P50), .PERIOD_60(P60), .PULSE_W(PW)
  ) dut_i (
    .clk(clk), .rst(rst), .vs_in(vs_in), .video_ok(video_ok),
    .coast_mode(coast_mode), .vs_out(vs_out)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Output monitor: rise times (in posedge numbers) and high widths
  always @(negedge clk) begin
    if (vs_out && !prev_out) begin
      prev_rise = last_rise;
      last_rise = cyc;
      rise_cnt  = rise_cnt + 1;
      hi_len    = 1;
    end else if (vs_out) begin
      hi_len = hi_len + 1;
    end else if (prev_out) begin
      last_width = hi_len;
    end
    prev_out = vs_out;
  end

  function automatic int exp_period(input logic [1:0] m, input bit have, input int lrn);
    if (m == 2'b01) return P50;
    if (m == 2'b10) return P60;
    return have ? lrn : P60;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_rises(input int target);
    for (int i = 0; i < 3000 && rise_cnt < target; i++) @(negedge clk);
    if (rise_cnt < target) chk(1'b0, "timeout waiting for vs_out", rise_cnt, target);
  endtask

  // n input pulses spaced by per; after the last one, return shortly after it falls
  task automatic send_pulses(input int n, input int per);
    for (int k = 0; k < n; k++) begin
      vs_in = 1'b1;
      in_rise = cyc + 1;
      idle(IN_W);
      vs_in = 1'b0;
      if (k == n - 1) idle(2);
      else            idle(per - IN_W);
    end
  endtask

  task automatic coast_check(input int exp, input string tag);
    int r0;
    r0 = rise_cnt;
    video_ok = 1'b0;
    wait_rises(r0 + 1);
    chk(last_rise - in_rise == exp, {tag, " / R7 first coast pulse"}, last_rise - in_rise, exp);
    wait_rises(r0 + 2);
    chk(last_rise - prev_rise == exp, {tag, " coast spacing"}, last_rise - prev_rise, exp);
    idle(PW + 2);
    chk(last_width == PW, "R8 coast pulse width", last_width, PW);
  endtask

  task automatic run_case(input logic [1:0] m, input int per, input int n, input string tag);
    coast_mode = m;
    video_ok = 1'b1;
    idle(10);
    send_pulses(n, per);
    chk(last_rise == in_rise, "R1 output follows input edge", last_rise, in_rise);
    chk(last_width == IN_W, "R1 output follows input width", last_width, IN_W);
    coast_check(exp_period(m, 1'b1, per), tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    idle(3);
    chk(vs_out == 1'b0, "R10 vs_out low in reset", vs_out, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(vs_out == 1'b0, "R10 vs_out low after reset", vs_out, 0);

    // No learned period yet, auto mode, no video
    wait_rises(1);
    wait_rises(2);
    chk(last_rise - prev_rise == P60, "R6 fallback to 60 Hz period", last_rise - prev_rise, P60);
    idle(PW + 2);
    chk(last_width == PW, "R8 fallback pulse width", last_width, PW);

    run_case(2'b00, 120, 3, "R2 learned period");
    run_case(2'b01, 120, 3, "R3 forced 50 Hz");
    run_case(2'b10, 120, 3, "R4 forced 60 Hz");
    run_case(2'b11, 90,  2, "R5 reserved acts as auto");
    run_case(2'b00, 260, 2, "R2 long learned period");

    // R9: one edge after video returns must not relearn
    run_case(2'b00, 120, 3, "R2 relearn 120");
    video_ok = 1'b1;
    idle(37);
    send_pulses(1, 100);
    coast_check(120, "R9 single edge keeps learned period");

    for (int r = 0; r < 8; r++) begin
      logic [1:0] m;
      int per, n;
      m   = 2'($urandom % 4);
      per = 60 + int'($urandom % 241);
      n   = 2 + int'($urandom % 3);
      run_case(m, per, n, (m == 2'b01) ? "R3 random" :
                          (m == 2'b10) ? "R4 random" :
                          (m == 2'b11) ? "R5 random" : "R2 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule